// File: doc/BRIEF.md
# Chained Register Core

This block is one link in a linear chain of register cores that share a small 16-bit bus. Each bus word carries an address, a data field, a direction flag and a valid flag. The core registers every word it receives from its upstream neighbour and presents it to its downstream neighbour one cycle later. Because every hop is a flop, the longest timing path only runs between adjacent cores. No central decoder is needed.

Each core owns a contiguous window of `N_OUT + N_IN` addresses starting at `BASE`. Cores placed earlier in the chain are given lower bases. The low offsets of the window hold host-writable registers, and each of these drives a 16-bit fabric output. The high offsets hold read-only registers that sample 16-bit fabric inputs every cycle. On a valid read that hits its window, the core replaces the forwarded data field with the addressed register. Every other word passes through unchanged. A write never produces a response, so the host confirms a write by reading the location afterwards.

Top module: `chain_reg_core`

## Requirements
- R1: While `rst` is high, and after it, until the first transaction arrives, `dn_valid`, `dn_addr`, `dn_data`, `dn_rw` and every `fab_out` bit are 0.
- R2: `dn_addr`, `dn_rw` and `dn_valid` equal the `up_addr`, `up_rw` and `up_valid` values from the previous clock edge.
- R3: When a word is not a valid read inside the window, `dn_data` equals the previous cycle's `up_data`. This covers writes, idle words and words outside the window, and it means a write gets no response.
- R4: A valid read (`up_rw`=0) at `BASE+i`, with i below `N_OUT`, puts output register i on `dn_data` one cycle later.
- R5: A valid write (`up_rw`=1) at `BASE+i`, with i below `N_OUT`, loads `up_data` into output register i. The register drives `fab_out[16*i+15:16*i]` from the next cycle.
- R6: A valid read at `BASE+N_OUT+j`, with j below `N_IN`, returns `fab_in[16*j+15:16*j]` as it was sampled on the previous clock edge.
- R7: A write to an input-register offset is ignored. `fab_out` does not change, and a later read still returns the sampled fabric value.
- R8: A read or write to an address outside `[BASE, BASE+N_OUT+N_IN)` changes no register.
- R9: A word with `up_valid`=0 changes no register, even when its address is inside the window and `up_rw`=1.
- R10: In a chain of two cores, each core services only its own window. The downstream core forwards the upstream core's read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_addr | input | 16 | Address from upstream neighbour |
| up_data | input | 16 | Data from upstream neighbour |
| up_rw | input | 1 | 1 = write, 0 = read |
| up_valid | input | 1 | Word is a transaction |
| dn_addr | output | 16 | Registered address to downstream |
| dn_data | output | 16 | Registered data, or read data on a hit |
| dn_rw | output | 1 | Registered direction flag |
| dn_valid | output | 1 | Registered valid flag |
| fab_out | output | 16*N_OUT | Host-writable registers, register i in bits 16*i+15:16*i |
| fab_in | input | 16*N_IN | Fabric values sampled into the read-only registers |

## Verification
A wrong address decode shows up one cycle later in one of two ways: `dn_data` carries register contents where it should have carried the upstream data, or it carries the upstream data where a register should have appeared. A protection or write-enable fault shows on `fab_out` one cycle after the offending write. A read issued afterwards exposes it again through the chain. A broken forwarding stage shows on the chain's far end two cycles after injection, as a missing valid or a changed address.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
   localparam int unsigned BUS_W = 16;

   typedef struct packed {
      logic [BUS_W-1:0] addr;
      logic [BUS_W-1:0] data;
      logic             rw;
      logic             valid;
   } bus_word_t;
endpackage

// File: rtl/addr_window_decode.sv
module addr_window_decode #(
   parameter int unsigned BASE  = 0,
   parameter int unsigned N_OUT = 2,
   parameter int unsigned N_IN  = 2,
   parameter int unsigned OFF_W = 2
) (
   input  logic [15:0]      addr,
   output logic             in_win,
   output logic             is_ro,
   output logic [OFF_W-1:0] off
);
   localparam int unsigned SIZE = N_OUT + N_IN;

   logic [16:0] rel;

   always_comb begin
      rel    = {1'b0, addr} - 17'(BASE);
      in_win = !rel[16] && (rel < 17'(SIZE));
      is_ro  = in_win && (rel >= 17'(N_OUT));
      off    = rel[OFF_W-1:0];
   end
endmodule

// File: rtl/out_reg_bank.sv
module out_reg_bank #(
   parameter int unsigned N_OUT = 2,
   parameter int unsigned OFF_W = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  we,
   input  logic [OFF_W-1:0]      off,
   input  logic [15:0]           wdata,
   output logic [16*N_OUT-1:0]   regs
);
   for (genvar i = 0; i < int'(N_OUT); i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs[16*i +: 16] <= '0;
         else if (we && off == OFF_W'(i))
            regs[16*i +: 16] <= wdata;
      end
   end
endmodule

// File: rtl/in_reg_bank.sv
module in_reg_bank #(
   parameter int unsigned N_IN          = 2,
   parameter bit          SAMPLE_INPUTS = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [16*N_IN-1:0]  fab_in,
   output logic [16*N_IN-1:0]  samp
);
   if (SAMPLE_INPUTS) begin : g_flop
      always_ff @(posedge clk) begin
         if (rst) samp <= '0;
         else     samp <= fab_in;
      end
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign samp = fab_in;
   end
endmodule

// File: rtl/chain_reg_core.sv
module chain_reg_core
   import regbus_pkg::*;
#(
   parameter int unsigned BASE          = 16'h0010,
   parameter int unsigned N_OUT         = 2,
   parameter int unsigned N_IN          = 2,
   parameter bit          SAMPLE_INPUTS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [15:0]          up_addr,
   input  logic [15:0]          up_data,
   input  logic                 up_rw,
   input  logic                 up_valid,
   output logic [15:0]          dn_addr,
   output logic [15:0]          dn_data,
   output logic                 dn_rw,
   output logic                 dn_valid,
   output logic [16*N_OUT-1:0]  fab_out,
   input  logic [16*N_IN-1:0]   fab_in
);
   localparam int unsigned SIZE  = N_OUT + N_IN;
   localparam int unsigned OFF_W = (SIZE > 1) ? $clog2(SIZE) : 1;

   if (N_OUT < 1 || N_IN < 1) begin : g_bad_count
      $error("chain_reg_core: N_OUT and N_IN must be at least 1");
   end
   if (BASE + SIZE > 65536) begin : g_bad_window
      $error("chain_reg_core: window exceeds 16-bit address space");
   end

   logic             in_win, is_ro, we;
   logic [OFF_W-1:0] off;
   logic [16*N_IN-1:0] samp;
   logic [15:0]      rdata;
   bus_word_t        stage_q;

   addr_window_decode #(.BASE(BASE), .N_OUT(N_OUT), .N_IN(N_IN), .OFF_W(OFF_W)) u_dec (
      .addr(up_addr), .in_win(in_win), .is_ro(is_ro), .off(off)
   );

   assign we = up_valid && up_rw && in_win && !is_ro;

   out_reg_bank #(.N_OUT(N_OUT), .OFF_W(OFF_W)) u_out (
      .clk(clk), .rst(rst), .we(we), .off(off), .wdata(up_data), .regs(fab_out)
   );

   in_reg_bank #(.N_IN(N_IN), .SAMPLE_INPUTS(SAMPLE_INPUTS)) u_in (
      .clk(clk), .rst(rst), .fab_in(fab_in), .samp(samp)
   );

   always_comb begin
      rdata = '0;
      for (int i = 0; i < int'(N_OUT); i++)
         if (off == OFF_W'(i)) rdata = fab_out[16*i +: 16];
      for (int j = 0; j < int'(N_IN); j++)
         if (off == OFF_W'(int'(N_OUT) + j)) rdata = samp[16*j +: 16];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
      end else begin
         stage_q.addr  <= up_addr;
         stage_q.rw    <= up_rw;
         stage_q.valid <= up_valid;
         stage_q.data  <= (up_valid && !up_rw && in_win) ? rdata : up_data;
      end
   end

   assign dn_addr  = stage_q.addr;
   assign dn_data  = stage_q.data;
   assign dn_rw    = stage_q.rw;
   assign dn_valid = stage_q.valid;
endmodule

// File: rtl/reg_core_chk.sv
module reg_core_chk #(
   parameter int unsigned BASE  = 16'h0010,
   parameter int unsigned N_OUT = 2,
   parameter int unsigned N_IN  = 2
) (
   input logic                clk,
   input logic                rst,
   input logic [15:0]         up_addr,
   input logic [15:0]         up_data,
   input logic                up_rw,
   input logic                up_valid,
   input logic [15:0]         dn_addr,
   input logic [15:0]         dn_data,
   input logic                dn_rw,
   input logic                dn_valid,
   input logic [16*N_OUT-1:0] fab_out
);
   localparam int unsigned SIZE = N_OUT + N_IN;

   logic a_in_win, a_out_wr;
   assign a_in_win = (32'(up_addr) >= BASE) && (32'(up_addr) < BASE + SIZE);
   assign a_out_wr = up_valid && up_rw && (32'(up_addr) >= BASE) && (32'(up_addr) < BASE + N_OUT);

   assert_fwd_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (dn_addr == $past(up_addr) && dn_rw == $past(up_rw) && dn_valid == $past(up_valid)));

   assert_data_pass_R3: assert property (@(posedge clk) disable iff (rst)
      !(up_valid && !up_rw && a_in_win) |=> dn_data == $past(up_data));

   assert_no_stray_write_R7: assert property (@(posedge clk) disable iff (rst)
      !a_out_wr |=> $stable(fab_out));

   for (genvar i = 0; i < int'(N_OUT); i++) begin : g_wr
      assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
         (up_valid && up_rw && 32'(up_addr) == BASE + i) |=> fab_out[16*i +: 16] == $past(up_data));
   end
endmodule

bind chain_reg_core reg_core_chk #(.BASE(BASE), .N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
   .clk(clk), .rst(rst), .up_addr(up_addr), .up_data(up_data), .up_rw(up_rw),
   .up_valid(up_valid), .dn_addr(dn_addr), .dn_data(dn_data), .dn_rw(dn_rw),
   .dn_valid(dn_valid), .fab_out(fab_out)
);

// File: tb/test_chain_reg_core.sv
module test_chain_reg_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] h_addr = '0, h_data = '0;
   logic        h_rw = 1'b0, h_valid = 1'b0;
   logic [15:0] m_addr, m_data, t_addr, t_data;
   logic        m_rw, m_valid, t_rw, t_valid;
   logic [31:0] out0, out1;
   logic [31:0] in0 = 32'hA1A1_B2B2, in1 = 32'hC3C3_D4D4;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // first link: window 0x10..0x13 (out 0x10,0x11; in 0x12,0x13)
   chain_reg_core #(.BASE(16'h0010), .N_OUT(2), .N_IN(2)) i_chain_reg_core (
      .clk(clk), .rst(rst), .up_addr(h_addr), .up_data(h_data), .up_rw(h_rw),
      .up_valid(h_valid), .dn_addr(m_addr), .dn_data(m_data), .dn_rw(m_rw),
      .dn_valid(m_valid), .fab_out(out0), .fab_in(in0)
   );
   // second link: window 0x20..0x23
   chain_reg_core #(.BASE(16'h0020), .N_OUT(2), .N_IN(2)) i_chain_reg_core_1 (
      .clk(clk), .rst(rst), .up_addr(m_addr), .up_data(m_data), .up_rw(m_rw),
      .up_valid(m_valid), .dn_addr(t_addr), .dn_data(t_data), .dn_rw(t_rw),
      .dn_valid(t_valid), .fab_out(out1), .fab_in(in1)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one word at a negedge, return at the negedge where the chain end shows it
   task automatic xfer(input logic [15:0] a, input logic [15:0] d, input logic w, input logic v);
      h_addr = a; h_data = d; h_rw = w; h_valid = v;
      @(negedge clk);
      h_valid = 1'b0; h_rw = 1'b0; h_addr = 16'hFFFF; h_data = 16'h0000;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 dn_valid", 32'(t_valid), 0);
      check("R1 dn_addr", 32'(t_addr), 0);
      check("R1 dn_data", 32'(t_data), 0);
      check("R1 fab_out core0", out0, 0);
      check("R1 fab_out core1", out1, 0);
   endtask

   task automatic t_write_out;
      xfer(16'h0010, 16'h1234, 1'b1, 1'b1);
      check("R5 core0 reg0", out0, 32'h0000_1234);
      check("R3 write passes data", 32'(t_data), 32'h1234);
      check("R2 addr/rw/valid", {13'b0, t_rw, t_valid, 1'b0, t_addr}, {13'b0, 1'b1, 1'b1, 1'b0, 16'h0010});
      xfer(16'h0021, 16'hBEEF, 1'b1, 1'b1);
      check("R10 core1 reg1 only", {out1, out0}, {32'hBEEF_0000, 32'h0000_1234});
   endtask

   task automatic t_read_out;
      xfer(16'h0010, 16'h5555, 1'b0, 1'b1);
      check("R4 R10 read core0 reg0 through core1", 32'(t_data), 32'h1234);
      xfer(16'h0021, 16'h0000, 1'b0, 1'b1);
      check("R4 read core1 reg1", 32'(t_data), 32'hBEEF);
      xfer(16'h0011, 16'h7777, 1'b0, 1'b1);
      check("R4 read core0 reg1 zero", 32'(t_data), 32'h0000);
   endtask

   task automatic t_read_in;
      xfer(16'h0012, 16'h0000, 1'b0, 1'b1);
      check("R6 core0 in0", 32'(t_data), 32'hB2B2);
      xfer(16'h0023, 16'h0000, 1'b0, 1'b1);
      check("R6 core1 in1 last offset", 32'(t_data), 32'hC3C3);
      in0 = 32'hA1A1_0F0F;
      @(negedge clk);
      xfer(16'h0012, 16'h0000, 1'b0, 1'b1);
      check("R6 core0 in0 new sample", 32'(t_data), 32'h0F0F);
   endtask

   task automatic t_ro_write;
      xfer(16'h0013, 16'hDEAD, 1'b1, 1'b1);
      check("R7 fab_out unchanged", {out1, out0}, {32'hBEEF_0000, 32'h0000_1234});
      xfer(16'h0013, 16'h0000, 1'b0, 1'b1);
      check("R7 ro reads sample", 32'(t_data), 32'hA1A1);
   endtask

   task automatic t_unmapped;
      xfer(16'h0014, 16'hCAFE, 1'b1, 1'b1);
      xfer(16'h0005, 16'hCAFE, 1'b1, 1'b1);
      xfer(16'h001F, 16'hCAFE, 1'b1, 1'b1);
      check("R8 unmapped writes", {out1, out0}, {32'hBEEF_0000, 32'h0000_1234});
      xfer(16'h0030, 16'h4321, 1'b0, 1'b1);
      check("R8 unmapped read passes data", 32'(t_data), 32'h4321);
   endtask

   task automatic t_idle;
      xfer(16'h0010, 16'h9999, 1'b1, 1'b0);
      check("R9 idle write ignored", out0, 32'h0000_1234);
      check("R9 idle valid low", 32'(t_valid), 0);
      xfer(16'h0020, 16'h6666, 1'b0, 1'b0);
      check("R9 idle read no insert", 32'(t_data), 32'h6666);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_write_out();
      t_read_out();
      t_read_in();
      t_ro_write();
      t_unmapped();
      t_idle();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule